// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block guesses, in the same cycle that a fetch address is presented, which address fetch should use next. It keeps two separate structures. The first is a table of 2-bit saturating counters, selected by the low word-address bits of the fetch PC, which decides taken or not taken. The second is a small fully associative buffer of branch targets, tagged by the word address. The target buffer is searched only when the counter table says taken. If that search hits, the stored address becomes the next fetch PC. Otherwise fetch continues at PC+4.

A taken guess with no stored target is flagged as a misfetch, and fetch stays sequential. Branches that the back end resolves come in through a resolve port. Each one steps its counter toward its real outcome. A branch that was really taken either refreshes its target entry or claims a new slot, and slots are handed out in round-robin order. The resolve port also compares the outcome with the guess the pipeline recorded. It reports a wrong direction and a wrong target as separate flags, and raises a common mispredict flag for either.

Top module: `fetch_bpred`

## Requirements
- R1: After reset every counter holds weakly-not-taken (2'b01) and every target slot is invalid, so any lookup gives pred_taken=0, pred_next_pc=fetch_pc+4 and misfetch=0.
- R2: Each counter saturates at 2'b00 and 2'b11 and predicts taken when its upper bit is 1. From either strong state, two opposite outcomes in a row are needed to flip the prediction.
- R3: The counter is selected by fetch_pc[IDX_W+1:2], so two PCs that differ only above that field share a counter.
- R4: When the counter predicts not taken, pred_next_pc is fetch_pc+4 and misfetch is 0, even if the target buffer holds an entry for that PC.
- R5: When the counter predicts taken and a valid target slot holds tag fetch_pc[PC_W-1:2], pred_next_pc is that slot's stored target and misfetch is 0.
- R6: When the counter predicts taken and no slot matches, pred_next_pc is fetch_pc+4 and misfetch is 1.
- R7: A resolve with res_taken=0 never writes the target buffer.
- R8: A taken resolve whose tag is already stored overwrites that slot's target and does not advance the replacement pointer.
- R9: A taken resolve whose tag is absent writes the slot at the round-robin pointer, which then advances by one and wraps. The ninth distinct allocation after reset evicts the first one.
- R10: While res_valid is 1, res_dir_miss is 1 exactly when res_taken differs from res_pred_taken. All resolve flags are 0 while res_valid is 0.
- R11: res_tgt_miss is 1 when res_valid, res_taken and res_pred_taken are all 1 and res_target differs from res_pred_target. res_mispredict is the OR of the two miss flags.
- R12: The prediction is combinational from fetch_pc and the stored state. A resolve changes the state at the next rising clock edge, so a lookup in the same cycle still sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_taken | output | 1 | Counter table predicts taken |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| misfetch | output | 1 | Taken prediction without a stored target |
| res_valid | input | 1 | A resolved branch is presented |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |
| res_target | input | PC_W | Actual target of the resolved branch |
| res_pred_taken | input | 1 | Direction the pipeline used for this branch |
| res_pred_target | input | PC_W | Next address the pipeline used for this branch |
| res_dir_miss | output | 1 | Direction was wrong |
| res_tgt_miss | output | 1 | Direction right and taken, but target wrong |
| res_mispredict | output | 1 | Either miss flag |

## Verification
A lookup and a resolve can address the same counter and the same target slot in the same cycle. The bench provokes this by presenting a taken resolve for a PC while that same PC sits on fetch_pc. It judges that the outputs sampled before the edge still show the reset-state sequential prediction, and that the redirected target appears only after the edge. A second overlap is between a refresh and an allocation in the target buffer. The bench re-resolves a stored branch with a new target and then fills the remaining slots. The refreshed entry must survive, and it would not if the refresh had consumed a slot.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // saturating step toward the resolved outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : cur + 2'd1;
    else       nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/fbp_dir_table.sv
`timescale 1ns/1ps
module fbp_dir_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_taken,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken
);
  import fbp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  ctr_t             ctr_q [DEPTH];
  ctr_t             ctr_d;
  logic [DEPTH-1:0] ctr_we;

  // next-state value for the entry being resolved
  always_comb begin
    ctr_d = ctr_step(ctr_q[up_idx], up_taken);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ctr
    assign ctr_we[e] = up_en && (up_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctr_q[e] <= CTR_WNT;
      else if (ctr_we[e]) ctr_q[e] <= ctr_d;
    end
  end

  always_comb begin
    lk_taken = ctr_taken(ctr_q[lk_idx]);
  end

endmodule

// File: rtl/fbp_tgt_buffer.sv
`timescale 1ns/1ps
module fbp_tgt_buffer #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 8,
  localparam int TAG_W  = PC_W - 2,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PC_W-1:0]  lk_target,
  input  logic             up_en,
  input  logic [TAG_W-1:0] up_tag,
  input  logic [PC_W-1:0]  up_target,
  output logic             up_hit,
  output logic [PTR_W-1:0] alloc_ptr
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] up_match;
  logic [ENTRIES-1:0] slot_we;
  logic [PTR_W-1:0]   hit_slot;
  logic [PTR_W-1:0]   wr_slot;
  logic [PTR_W-1:0]   ptr_q;
  logic [PTR_W-1:0]   ptr_d;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lk_match[e] = lk_en && valid_q[e] && (tag_q[e] == lk_tag);
    assign up_match[e] = valid_q[e] && (tag_q[e] == up_tag);
  end

  // tags are unique, so at most one match: OR-reduce the targets
  always_comb begin
    lk_target = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_match[e]) lk_target = lk_target | tgt_q[e];
    end
  end
  assign lk_hit = |lk_match;

  always_comb begin
    hit_slot = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (up_match[e]) hit_slot = PTR_W'(e);
    end
  end
  assign up_hit  = |up_match;
  assign wr_slot = up_hit ? hit_slot : ptr_q;

  // replacement pointer next state: advance only on a fresh allocation
  always_comb begin
    ptr_d = ptr_q;
    if (up_en && !up_hit) begin
      ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
  assign alloc_ptr = ptr_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    assign slot_we[e] = up_en && (wr_slot == PTR_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          valid_q[e] <= 1'b0;
      else if (slot_we[e]) valid_q[e] <= 1'b1;
    end

    // payload carries no reset: qualified by valid_q
    always_ff @(posedge clk) begin
      if (slot_we[e]) begin
        tag_q[e] <= up_tag;
        tgt_q[e] <= up_target;
      end
    end
  end

endmodule

// File: rtl/fbp_resolve_cmp.sv
`timescale 1ns/1ps
module fbp_resolve_cmp #(
  parameter int PC_W = 32
) (
  input  logic            res_valid,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_pred_taken,
  input  logic [PC_W-1:0] res_pred_target,
  output logic            dir_miss,
  output logic            tgt_miss,
  output logic            mispredict
);

  always_comb begin
    dir_miss   = res_valid && (res_taken != res_pred_taken);
    tgt_miss   = res_valid && res_taken && res_pred_taken &&
                 (res_target != res_pred_target);
    mispredict = dir_miss || tgt_miss;
  end

endmodule

// File: rtl/fetch_bpred.sv
`timescale 1ns/1ps
module fetch_bpred #(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 6,
  parameter int TB_ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next_pc,
  output logic            misfetch,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_pred_taken,
  input  logic [PC_W-1:0] res_pred_target,
  output logic            res_dir_miss,
  output logic            res_tgt_miss,
  output logic            res_mispredict
);

  localparam int TAG_W = PC_W - 2;
  localparam int PTR_W = (TB_ENTRIES > 1) ? $clog2(TB_ENTRIES) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic             dir_taken;
  logic             tb_hit;
  logic [PC_W-1:0]  tb_target;
  logic             tb_up_hit;
  logic [PTR_W-1:0] alloc_ptr;
  logic [PC_W-1:0]  seq_pc;
  logic             unused_lsb;

  assign unused_lsb = ^res_pc[1:0];
  assign seq_pc     = fetch_pc + PC_W'(4);

  fbp_dir_table #(
    .IDX_W (IDX_W)
  ) dir_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lk_idx   (fetch_pc[IDX_W+1:2]),
    .lk_taken (dir_taken),
    .up_en    (res_valid),
    .up_idx   (res_pc[IDX_W+1:2]),
    .up_taken (res_taken)
  );

  fbp_tgt_buffer #(
    .PC_W    (PC_W),
    .ENTRIES (TB_ENTRIES)
  ) tb_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lk_en     (dir_taken),
    .lk_tag    (fetch_pc[PC_W-1:2]),
    .lk_hit    (tb_hit),
    .lk_target (tb_target),
    .up_en     (res_valid && res_taken),
    .up_tag    (res_pc[PC_W-1:2]),
    .up_target (res_target),
    .up_hit    (tb_up_hit),
    .alloc_ptr (alloc_ptr)
  );

  fbp_resolve_cmp #(
    .PC_W (PC_W)
  ) cmp_i (
    .res_valid       (res_valid),
    .res_taken       (res_taken),
    .res_target      (res_target),
    .res_pred_taken  (res_pred_taken),
    .res_pred_target (res_pred_target),
    .dir_miss        (res_dir_miss),
    .tgt_miss        (res_tgt_miss),
    .mispredict      (res_mispredict)
  );

  always_comb begin
    pred_taken   = dir_taken;
    misfetch     = dir_taken && !tb_hit;
    pred_next_pc = (dir_taken && tb_hit) ? tb_target : seq_pc;
  end

  logic [TAG_W-1:0] unused_tag_w;
  assign unused_tag_w = '0;

endmodule

// File: rtl/fetch_bpred_chk.sv
`timescale 1ns/1ps
module fetch_bpred_chk #(
  parameter int PC_W  = 32,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             pred_taken,
  input logic [PC_W-1:0]  pred_next_pc,
  input logic             misfetch,
  input logic             res_valid,
  input logic             res_taken,
  input logic             res_pred_taken,
  input logic             res_dir_miss,
  input logic             res_tgt_miss,
  input logic             res_mispredict,
  input logic             tb_up_hit,
  input logic [PTR_W-1:0] alloc_ptr
);

  AST_SEQ_WHEN_NT: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> (pred_next_pc == fetch_pc + PC_W'(4)) && !misfetch); // R4

  AST_MISFETCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    misfetch |-> pred_taken && (pred_next_pc == fetch_pc + PC_W'(4))); // R6

  AST_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_dir_miss && res_tgt_miss)); // R10

  AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_mispredict && !res_dir_miss && !res_tgt_miss); // R10

  AST_TGT_MISS_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    res_tgt_miss |-> res_taken && res_pred_taken && res_mispredict); // R11

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken && !tb_up_hit) |=> alloc_ptr == $past(alloc_ptr) + PTR_W'(1)); // R9

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_taken && !tb_up_hit) |=> $stable(alloc_ptr)); // R8

  AST_QUIET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (!$stable(fetch_pc) || ($stable(pred_next_pc) && $stable(misfetch)))); // R12

endmodule

bind fetch_bpred fetch_bpred_chk #(
  .PC_W  (PC_W),
  .PTR_W (PTR_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .fetch_pc       (fetch_pc),
  .pred_taken     (pred_taken),
  .pred_next_pc   (pred_next_pc),
  .misfetch       (misfetch),
  .res_valid      (res_valid),
  .res_taken      (res_taken),
  .res_pred_taken (res_pred_taken),
  .res_dir_miss   (res_dir_miss),
  .res_tgt_miss   (res_tgt_miss),
  .res_mispredict (res_mispredict),
  .tb_up_hit      (tb_up_hit),
  .alloc_ptr      (alloc_ptr)
);

// File: tb/fetch_bpred_tb_top.sv
`timescale 1ns/1ps
module fetch_bpred_tb_top;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_taken;
  logic [PC_W-1:0] pred_next_pc;
  logic            misfetch;
  logic            res_valid = 1'b0;
  logic [PC_W-1:0] res_pc = '0;
  logic            res_taken = 1'b0;
  logic [PC_W-1:0] res_target = '0;
  logic            res_pred_taken = 1'b0;
  logic [PC_W-1:0] res_pred_target = '0;
  logic            res_dir_miss;
  logic            res_tgt_miss;
  logic            res_mispredict;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fetch_bpred #(.PC_W(PC_W), .IDX_W(6), .TB_ENTRIES(8)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_pc        (fetch_pc),
    .pred_taken      (pred_taken),
    .pred_next_pc    (pred_next_pc),
    .misfetch        (misfetch),
    .res_valid       (res_valid),
    .res_pc          (res_pc),
    .res_taken       (res_taken),
    .res_target      (res_target),
    .res_pred_taken  (res_pred_taken),
    .res_pred_target (res_pred_target),
    .res_dir_miss    (res_dir_miss),
    .res_tgt_miss    (res_tgt_miss),
    .res_mispredict  (res_mispredict)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    res_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // present a PC and compare all three prediction outputs
  task automatic lookup(input string req, input logic [31:0] pc, input logic exp_tk,
                        input logic [31:0] exp_nxt, input logic exp_mf);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    check({req, " pred_taken"}, 32'(pred_taken), 32'(exp_tk));
    check({req, " next_pc"}, pred_next_pc, exp_nxt);
    check({req, " misfetch"}, 32'(misfetch), 32'(exp_mf));
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
    res_pred_taken = tk; res_pred_target = tgt;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic resolve_flags(input string req, input logic tk, input logic [31:0] tgt,
                               input logic ptk, input logic [31:0] ptgt,
                               input logic e_dir, input logic e_tgt, input logic e_mis);
    @(negedge clk);
    res_valid = 1'b1; res_pc = 32'h3000; res_taken = tk; res_target = tgt;
    res_pred_taken = ptk; res_pred_target = ptgt;
    #1;
    check({req, " dir_miss"}, 32'(res_dir_miss), 32'(e_dir));
    check({req, " tgt_miss"}, 32'(res_tgt_miss), 32'(e_tgt));
    check({req, " mispredict"}, 32'(res_mispredict), 32'(e_mis));
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    lookup("R1 pc0", 32'h0, 1'b0, 32'h4, 1'b0);
    lookup("R1 pc100", 32'h100, 1'b0, 32'h104, 1'b0);
    lookup("R1 pcfffc", 32'hFFFC, 1'b0, 32'h10000, 1'b0);
    check("R1 idle mispredict", 32'(res_mispredict), 32'h0);
  endtask

  task automatic t_counter();
    do_reset();
    resolve(32'h100, 1'b1, 32'h400);                    // 01 -> 10
    lookup("R2 one taken", 32'h100, 1'b1, 32'h400, 1'b0);
    lookup("R5 hit target", 32'h100, 1'b1, 32'h400, 1'b0);
    resolve(32'h100, 1'b1, 32'h400);                    // -> 11
    resolve(32'h100, 1'b0, 32'h0);                      // -> 10
    lookup("R2 first wrong keeps taken", 32'h100, 1'b1, 32'h400, 1'b0);
    resolve(32'h100, 1'b0, 32'h0);                      // -> 01
    lookup("R2 second wrong flips", 32'h100, 1'b0, 32'h104, 1'b0);
    resolve(32'h100, 1'b0, 32'h0);                      // -> 00
    resolve(32'h100, 1'b1, 32'h400);                    // -> 01
    lookup("R2 first taken from strong NT", 32'h100, 1'b0, 32'h104, 1'b0);
    resolve(32'h100, 1'b1, 32'h400);                    // -> 10
    lookup("R2 second taken flips", 32'h100, 1'b1, 32'h400, 1'b0);
  endtask

  task automatic t_alias_nt_no_alloc();
    do_reset();
    resolve(32'h100, 1'b1, 32'h400);
    resolve(32'h100, 1'b1, 32'h400);                    // shared counter -> 11
    lookup("R3 R6 alias misfetch", 32'h200, 1'b1, 32'h204, 1'b1);
    resolve(32'h200, 1'b0, 32'h0);                      // -> 10, no allocation
    lookup("R7 NT resolve not stored", 32'h200, 1'b1, 32'h204, 1'b1);
    lookup("R7 owner entry intact", 32'h100, 1'b1, 32'h400, 1'b0);
  endtask

  task automatic t_gate();
    do_reset();
    resolve(32'h100, 1'b1, 32'h400);
    resolve(32'h100, 1'b1, 32'h400);
    resolve(32'h100, 1'b0, 32'h0);
    resolve(32'h100, 1'b0, 32'h0);                      // -> 01, entry still held
    lookup("R4 NT ignores buffer", 32'h100, 1'b0, 32'h104, 1'b0);
    resolve(32'h100, 1'b1, 32'h400);                    // -> 10
    lookup("R4 R5 entry reused", 32'h100, 1'b1, 32'h400, 1'b0);
  endtask

  task automatic t_refresh();
    do_reset();
    resolve(32'h100, 1'b1, 32'h400);
    resolve(32'h100, 1'b1, 32'h400);
    resolve(32'h100, 1'b1, 32'h800);
    lookup("R8 target refreshed", 32'h100, 1'b1, 32'h800, 1'b0);
    for (int i = 1; i < 8; i++) resolve(32'h1000 + 32'(i) * 4, 1'b1, 32'h5000 + 32'(i) * 16);
    lookup("R8 refresh kept slot count", 32'h100, 1'b1, 32'h800, 1'b0);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < 9; i++) resolve(32'h2000 + 32'(i) * 4, 1'b1, 32'h9000 + 32'(i) * 16);
    lookup("R9 first evicted", 32'h2000, 1'b1, 32'h2004, 1'b1);
    lookup("R9 second kept", 32'h2004, 1'b1, 32'h9010, 1'b0);
    lookup("R9 ninth stored", 32'h2020, 1'b1, 32'h9080, 1'b0);
  endtask

  task automatic t_flags();
    do_reset();
    resolve_flags("R10 NT/T",  1'b1, 32'h40, 1'b0, 32'h0,  1'b1, 1'b0, 1'b1);
    resolve_flags("R10 T/NT",  1'b0, 32'h0,  1'b1, 32'h40, 1'b1, 1'b0, 1'b1);
    resolve_flags("R11 T/T ok", 1'b1, 32'h40, 1'b1, 32'h40, 1'b0, 1'b0, 1'b0);
    resolve_flags("R11 T/T bad target", 1'b1, 32'h40, 1'b1, 32'h80, 1'b0, 1'b1, 1'b1);
    resolve_flags("R10 NT/NT", 1'b0, 32'h0,  1'b0, 32'h3004, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    @(negedge clk);
    fetch_pc  = 32'h100;
    res_valid = 1'b1; res_pc = 32'h100; res_taken = 1'b1; res_target = 32'h400;
    res_pred_taken = 1'b1; res_pred_target = 32'h400;
    #1;
    check("R12 old state before edge taken", 32'(pred_taken), 32'h0);
    check("R12 old state before edge next", pred_next_pc, 32'h104);
    @(negedge clk);
    res_valid = 1'b0;
    #1;
    check("R12 new state after edge taken", 32'(pred_taken), 32'h1);
    check("R12 new state after edge next", pred_next_pc, 32'h400);
  endtask

  initial begin
    t_reset_state();
    t_counter();
    t_alias_nt_no_alloc();
    t_gate();
    t_refresh();
    t_round_robin();
    t_flags();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule